// File: doc/BRIEF.md
# Addressable Step Attenuator Control Register

This block is the digital control core of a seven-bit step attenuator. It produces the attenuation code that sets the switched array, where each code step is a quarter unit of attenuation. Software programs the code in one of two ways. A mode input picks between them.

In serial mode, a 16-bit word is shifted in over a data pin and a shift clock. The low byte is the attenuation code and the high byte is an address. The word takes effect on a rising latch enable, and only if its low three address bits equal the three strapped address pins. In parallel mode, seven input lines carry the code. Latch enable then works in one of two ways. Held high, it makes the output follow the lines directly. Pulsed high and then low, it captures the lines, and they are held after the pulse.

All inputs are asynchronous levels. A free-running system clock samples them through synchronizer flops, and the serial clock and latch enable are turned into edge strobes on that clock. There is no data stream and no back-pressure; every pin is plain control.

Top module: `atten_word_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until a word is applied, the attenuation output is 127 (all bits set) and the error flag is 0.
- R2: In serial mode (mode input 1), each rising edge of the shift clock seen while latch enable is low shifts one data bit in. The first bit shifted becomes word bit 0. Word bits 6..0 form the code, bit 7 is the reserved code bit, and bits 15..8 form the address byte. A matching word with bit 7 at 0 loads bits 6..0 into the output.
- R3: Only word bits 10..8 are compared with the address pins, bit 8 against pin bit 0. Word bits 15..11 have no effect.
- R4: A rising latch enable in serial mode with an address mismatch leaves the output unchanged and raises no error.
- R5: While a word is being shifted in, the output keeps its value, and the shift register does not move while latch enable is high.
- R6: A matching word with bit 7 at 1 leaves the output unchanged and raises the error flag for exactly one clock cycle.
- R7: The mode input at 0 selects parallel mode and at 1 selects serial mode. In serial mode the parallel lines have no effect. In parallel mode the shift clock neither changes the output nor shifts the register.
- R8: In parallel mode with latch enable low, changes on the parallel lines are ignored. A latch enable pulse (high, then low) leaves the lines' value on the output.
- R9: In parallel mode with latch enable held high, the output follows the parallel lines.
- R10: Any input change reaches the output on the third rising system clock edge after it: two synchronizer flops, then the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ser | input | 1 | 1 selects serial, 0 selects parallel |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock (rising edge shifts) |
| latch_en | input | 1 | Latch enable |
| addr_pins | input | 3 | Strapped device address |
| par_code | input | 7 | Parallel attenuation code |
| atten_code | output | 7 | Current attenuation state, bit 0 is one quarter step |
| word_err | output | 1 | One-cycle pulse when a matching serial word has bit 7 set |

## Verification
Every result is due on the third rising clock edge after the input that causes it. The code output, the error pulse and each serial shift all follow this rule. The error flag drops again on the fourth edge. The bench changes inputs only on falling edges and waits exactly three rising edges before it samples, on the next falling edge. Latency is tested at the edge itself: the output is checked for its old value after two rising edges and for its new value after the third. Serial bits are spaced several cycles apart, so each one is synchronized and shifted before the next arrives.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int ATT_W   = 7;
  localparam int ADDR_W  = 3;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int SYNC_N  = 2;
  localparam logic [ATT_W-1:0] ATT_MAX = '1;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] st [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[g] <= '0;
      else        st[g] <= st[g-1];
    end
  end

  assign q      = st[STAGES-1];
  assign q_prev = st[STAGES];
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {bit_in, word[WORD_W-1:1]};
  end
endmodule

// File: rtl/atten_state.sv
module atten_state
  import atten_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_s,
  input  logic              le_s,
  input  logic              le_rise,
  input  logic              le_fall,
  input  logic [ATT_W-1:0]  par_s,
  input  logic [ADDR_W-1:0] pins_s,
  input  logic [WORD_W-1:0] word,
  output logic [ATT_W-1:0]  state_q,
  output logic              err_q
);
  logic addr_hit;
  logic resv_bit;

  assign addr_hit = (word[BYTE_W +: ADDR_W] == pins_s);
  assign resv_bit = word[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ATT_MAX;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (mode_s) begin
        if (le_rise && addr_hit) begin
          if (resv_bit) err_q   <= 1'b1;
          else          state_q <= word[ATT_W-1:0];
        end
      end else if (le_s || le_fall) begin
        state_q <= par_s;
      end
    end
  end

  // R4
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && le_rise && !addr_hit) |=> ($stable(state_q) && !err_q));
  // R6
  bad_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && le_rise && addr_hit && resv_bit) |=> ($stable(state_q) && err_q));
  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);
  // R5
  serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && !le_rise) |=> $stable(state_q));
  // R8
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && !le_s && !le_fall) |=> $stable(state_q));
endmodule

// File: rtl/atten_word_ctrl.sv
module atten_word_ctrl
  import atten_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ser,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              latch_en,
  input  logic [ADDR_W-1:0] addr_pins,
  input  logic [ATT_W-1:0]  par_code,
  output logic [ATT_W-1:0]  atten_code,
  output logic              word_err
);
  localparam int IN_W = 4 + ADDR_W + ATT_W;

  logic [IN_W-1:0] raw, cur, prv;
  logic              mode_s, sd_s, sck_s, sck_p, le_s, le_p;
  logic [ADDR_W-1:0] pins_s;
  logic [ATT_W-1:0]  par_s;
  logic [WORD_W-1:0] sr_word;
  logic              sck_rise, le_rise, le_fall, shift_en;

  assign raw = {mode_ser, ser_data, ser_clk, latch_en, addr_pins, par_code};

  sync_chain #(.W(IN_W), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(cur), .q_prev(prv));

  assign {mode_s, sd_s, sck_s, le_s, pins_s, par_s} = cur;
  assign sck_p    = prv[ADDR_W+ATT_W+1];
  assign le_p     = prv[ADDR_W+ATT_W];
  assign sck_rise = sck_s & ~sck_p;
  assign le_rise  = le_s & ~le_p;
  assign le_fall  = ~le_s & le_p;
  assign shift_en = sck_rise & ~le_s & mode_s;

  word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(sd_s), .word(sr_word));

  atten_state u_state (
    .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .le_s(le_s),
    .le_rise(le_rise), .le_fall(le_fall), .par_s(par_s), .pins_s(pins_s),
    .word(sr_word), .state_q(atten_code), .err_q(word_err));

  // R5
  shift_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_s |=> $stable(sr_word));
  // R7
  par_mode_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |=> $stable(sr_word));
endmodule

// File: tb/atten_word_ctrl_test.sv
`timescale 1ns/1ps
module atten_word_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_ser = 1'b1, ser_data = 1'b0, ser_clk = 1'b0, latch_en = 1'b0;
  logic [2:0] addr_pins = 3'd0;
  logic [6:0] par_code = 7'd0;
  logic [6:0] atten_code;
  logic       word_err;
  int         n_vec = 0, n_bad = 0;

  always #2 clk = ~clk;

  atten_word_ctrl uut (.*);

  // {address pins, serial word}
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 16'hF84A}, {3'd3, 16'h0349}, {3'd3, 16'h0510}, {3'd3, 16'hFB00},
    {3'd3, 16'h0385}, {3'd7, 16'h077F}, {3'd2, 16'h0201}, {3'd6, 16'h0640}};

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int b = 0; b < 16; b++) begin
      ser_clk = 1'b0; ser_data = w[b]; step(3);
      ser_clk = 1'b1; step(3);
    end
    ser_clk = 1'b0; step(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [6:0] model;
    step(3);
    chk("R1 reset code", atten_code, 7'h7F);
    chk("R1 reset err", word_err, 0);
    rst_n = 1'b1; step(5);
    chk("R1 post-reset code", atten_code, 7'h7F);
    model = 7'h7F;

    // serial vectors: R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      logic [15:0] w;
      logic [2:0]  p;
      logic        hit, bad;
      {p, w} = VEC[i];
      addr_pins = p;
      par_code = 7'(i * 13);  // R7: parallel lines ignored in serial mode
      shift_word(w);
      chk("R5 hold during shift", atten_code, model);
      hit = (w[10:8] == p);
      bad = hit && w[7];
      latch_en = 1'b1; step(3);
      if (hit && !w[7]) model = w[6:0];
      chk("R2/R3/R4 code after latch", atten_code, model);
      chk("R6 err pulse", word_err, bad);
      step(1);
      chk("R6 err one cycle", word_err, 0);
      latch_en = 1'b0; step(3);
    end

    // R9 direct parallel, R10 latency
    mode_ser = 1'b0; latch_en = 1'b1; par_code = 7'h11; step(6);
    chk("R9 direct follow", atten_code, 7'h11);
    par_code = 7'h6C; step(2);
    chk("R10 not yet at edge 2", atten_code, 7'h11);
    step(1);
    chk("R10 due at edge 3", atten_code, 7'h6C);

    // R8 latched parallel
    latch_en = 1'b0; step(4);
    par_code = 7'h03; step(5);
    chk("R8 ignored while latch low", atten_code, 7'h6C);
    latch_en = 1'b1; step(3);
    latch_en = 1'b0; step(4);
    chk("R8 captured by pulse", atten_code, 7'h03);
    par_code = 7'h70; step(5);
    chk("R8 held after pulse", atten_code, 7'h03);

    // R7 serial clock ignored in parallel mode
    addr_pins = 3'd0;
    shift_word(16'h0015);
    chk("R7 shift in parallel mode", atten_code, 7'h03);
    mode_ser = 1'b1; step(4);
    latch_en = 1'b1; step(3);
    chk("R7 no word shifted in parallel mode", atten_code, 7'h03);
    latch_en = 1'b0; step(3);
    shift_word(16'h0022);
    latch_en = 1'b1; step(3);
    chk("R7 serial after mode return", atten_code, 7'h22);
    latch_en = 1'b0; step(3);

    // R1 reset mid-run
    rst_n = 1'b0; step(1);
    chk("R1 reset mid-run", atten_code, 7'h7F);
    rst_n = 1'b1; step(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule